// File: doc/BRIEF.md
# Converter Bus Bridge for Two ADCs and a Dual DAC

This block is a slave on a simple synchronous system bus. A bus master raises a request with a byte address, a direction and write data, and holds them until the bridge returns a one-cycle ready. The bridge decodes a small word-addressed window. It turns accesses that land on the converters into chip-select, read-strobe and write-strobe activity for two parallel 16-bit ADCs and one parallel DAC with two channels.

Next to the converter paths sit two local registers. One is a read-only mirror of the two ADC busy lines. The other is a read/write bit that drives the DAC's active-low clear input. Register accesses answer at once.

Converter accesses are stretched to a fixed length. When converter accesses follow one another with no gap, every access after the first is longer still, so that slow parallel converters get recovery time. The DAC latches each written word at once: no load strobe exists.

Top module: `adcdac_bridge`

## Requirements
- R1: Decoding uses the word-aligned byte address. Any address with bits [1:0] nonzero, or with bits above the region field nonzero, is unmapped. The region field is bits [21:20]. Region 0 holds the status word at 0x000000 and the clear word at 0x000004. ADC1 reads at 0x100000. ADC2 reads at 0x200000. The DAC is written at 0x300000 (channel A) and 0x300004 (channel B).
- R2: A read of the status word returns ADC1 busy in bit 0 and ADC2 busy in bit 1, taken live from `adc_busy[0]` and `adc_busy[1]`. All other bits read 0. A write to the status word changes nothing.
- R3: A write to the clear word stores bus bit 0, and that bit drives `dac_clr_n` from the next cycle on. A read of the clear word returns the stored bit in bit 0. Reset clears the bit, so `dac_clr_n` is low after reset.
- R4: Status and clear-word accesses, read or write, complete with `bus_ready` high in the first cycle of the request.
- R5: A converter access that does not immediately follow another converter access raises `bus_ready` in the 4th cycle that the request is held.
- R6: A converter access whose request arrives in the cycle right after a converter access completes raises `bus_ready` in its 7th cycle. An idle cycle or a register access in between resets the length to 4.
- R7: During an ADC read, the chip select of that ADC alone and `conv_rd_n` are low from the 2nd cycle of the access through its ready cycle. The bus read data is the 16-bit sample of the selected ADC in the ready cycle.
- R8: During a DAC write, `dac_cs_n` and `conv_wr_n` are low from the 2nd cycle through the ready cycle. `dac_data` carries bus bits [15:0] and `dac_chan_sel` is 0 for channel A and 1 for channel B. Both hold their values after the access.
- R9: An unmapped address, a write to an ADC location, a read from a DAC location, or a misaligned address completes in one cycle. Reads return 0, no chip select or strobe is asserted, and no register changes.
- R10: During and right after reset, all chip selects and both strobes are high (inactive) and `bus_ready` is low while no request is present.
- R11: At most one chip select is low at a time. A strobe is low only while a chip select is low. All chip selects return high in the cycle after a converter access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address within the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the ready cycle |
| bus_ready | output | 1 | Access completes in this cycle |
| adc_busy | input | 2 | Busy lines of ADC1 (bit 0) and ADC2 (bit 1) |
| adc1_data | input | 16 | Parallel sample bus of ADC1 |
| adc2_data | input | 16 | Parallel sample bus of ADC2 |
| adc_cs_n | output | 2 | Active-low selects of ADC1 (bit 0) and ADC2 (bit 1) |
| dac_cs_n | output | 1 | Active-low DAC select |
| conv_rd_n | output | 1 | Active-low converter read strobe |
| conv_wr_n | output | 1 | Active-low converter write strobe |
| dac_chan_sel | output | 1 | DAC channel, 0 = A, 1 = B |
| dac_data | output | 16 | Word presented to the DAC |
| dac_clr_n | output | 1 | Active-low DAC clear |

## Verification
The hardest case to reach is the 7-cycle access. It only occurs when a new converter request is presented in the very cycle after the previous ready, so the bench keeps the request line high across the completing edge and loads the next address at the following falling edge. Chains of three converter accesses mixing ADC reads and DAC writes prove that the extra wait applies to every later access. Chains broken by one idle cycle, and chains broken by a status read, prove that the length falls back to 4.

// File: rtl/adcdac_pkg.sv
package adcdac_pkg;

   // kind of bus access after decoding
   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_STATUS = 2'd1,
      ACC_CLEAR  = 2'd2,
      ACC_CONV   = 2'd3
   } acc_kind_t;

   // top address field selects one of four regions
   typedef enum logic [1:0] {
      RGN_CTRL = 2'd0,
      RGN_ADC1 = 2'd1,
      RGN_ADC2 = 2'd2,
      RGN_DAC  = 2'd3
   } region_t;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_t;

   localparam int NUM_DEV  = 3;
   localparam int DEV_ADC1 = 0;
   localparam int DEV_ADC2 = 1;
   localparam int DEV_DAC  = 2;
   localparam int NUM_BUSY = 2;

endpackage

// File: rtl/adcdac_decode.sv
module adcdac_decode
   import adcdac_pkg::*;
#(
   parameter int ADDR_W     = 22,
   parameter int REGION_LSB = 20
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               write,
   output acc_kind_t          kind,
   output logic [NUM_DEV-1:0] dev_sel,
   output logic               dac_chan
);

   localparam int WORD_W  = REGION_LSB - 2;
   localparam int TOP_LSB = REGION_LSB + 2;

   logic              high_zero;
   logic              aligned;
   region_t           region;
   logic [WORD_W-1:0] word;

   // bits above the region field, if any, must be zero
   generate
      if (ADDR_W > TOP_LSB) begin : g_high
         assign high_zero = ~|addr[ADDR_W-1:TOP_LSB];
      end else begin : g_nohigh
         assign high_zero = 1'b1;
      end
   endgenerate

   assign aligned = (addr[1:0] == 2'b00);
   assign region  = region_t'(addr[REGION_LSB+1:REGION_LSB]);
   assign word    = addr[REGION_LSB-1:2];

   always_comb begin
      kind     = ACC_NONE;
      dev_sel  = '0;
      dac_chan = 1'b0;
      if (high_zero && aligned) begin
         case (region)
            RGN_CTRL: begin
               if (word == '0 && !write)
                  kind = ACC_STATUS;
               else if (word == WORD_W'(1))
                  kind = ACC_CLEAR;
            end
            RGN_ADC1: begin
               if (word == '0 && !write) begin
                  kind              = ACC_CONV;
                  dev_sel[DEV_ADC1] = 1'b1;
               end
            end
            RGN_ADC2: begin
               if (word == '0 && !write) begin
                  kind              = ACC_CONV;
                  dev_sel[DEV_ADC2] = 1'b1;
               end
            end
            RGN_DAC: begin
               if (write && (word == '0 || word == WORD_W'(1))) begin
                  kind             = ACC_CONV;
                  dev_sel[DEV_DAC] = 1'b1;
                  dac_chan         = word[0];
               end
            end
            default: kind = ACC_NONE;
         endcase
      end
   end

endmodule

// File: rtl/adcdac_sequencer.sv
module adcdac_sequencer
   import adcdac_pkg::*;
#(
   parameter int BASE_CYCLES = 4,
   parameter int EXTRA_WAIT  = 3,
   parameter int SAMPLE_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_req,
   input  logic [NUM_DEV-1:0]  dev_sel_in,
   input  logic                write_in,
   input  logic                chan_in,
   input  logic [SAMPLE_W-1:0] wdata_in,
   output logic                done,
   output logic                active,
   output logic [NUM_DEV-1:0]  dev_q,
   output logic [NUM_DEV-1:0]  cs_n,
   output logic                rd_n,
   output logic                wr_n,
   output logic                dac_chan,
   output logic [SAMPLE_W-1:0] dac_data
);

   localparam int LONG_CYCLES = BASE_CYCLES + EXTRA_WAIT;
   localparam int CNT_W       = $clog2(LONG_CYCLES + 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(BASE_CYCLES - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_q;
   logic             chain_q;
   logic             write_q;

   assign active = (state == SEQ_BUSY);
   assign done   = active && (cnt == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         cnt      <= '0;
         last_q   <= SHORT_LAST;
         chain_q  <= 1'b0;
         write_q  <= 1'b0;
         dev_q    <= '0;
         dac_chan <= 1'b0;
         dac_data <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               chain_q <= 1'b0;
               if (start_req) begin
                  state   <= SEQ_BUSY;
                  cnt     <= CNT_W'(1);
                  last_q  <= chain_q ? LONG_LAST : SHORT_LAST;
                  dev_q   <= dev_sel_in;
                  write_q <= write_in;
                  if (write_in) begin
                     dac_chan <= chan_in;
                     dac_data <= wdata_in;
                  end
               end
            end
            SEQ_BUSY: begin
               if (done) begin
                  state   <= SEQ_IDLE;
                  cnt     <= '0;
                  chain_q <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // one select per device, active only while the access runs
   genvar gi;
   generate
      for (gi = 0; gi < NUM_DEV; gi++) begin : g_cs
         assign cs_n[gi] = ~(active & dev_q[gi]);
      end
   endgenerate

   assign rd_n = ~(active & ~write_q);
   assign wr_n = ~(active & write_q);

endmodule

// File: rtl/adcdac_ctrl_regs.sv
module adcdac_ctrl_regs
   import adcdac_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_we,
   input  logic                clr_wbit,
   input  logic [NUM_BUSY-1:0] busy_in,
   output logic                clr_q,
   output logic [BUS_W-1:0]    status_word,
   output logic [BUS_W-1:0]    clr_word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         clr_q <= 1'b0;
      else if (clr_we)
         clr_q <= clr_wbit;
   end

   assign status_word = BUS_W'(busy_in);
   assign clr_word    = BUS_W'(clr_q);

endmodule

// File: rtl/adcdac_bridge.sv
module adcdac_bridge
   import adcdac_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int REGION_LSB  = 20,
   parameter int BUS_W       = 16,
   parameter int SAMPLE_W    = 16,
   parameter int BASE_CYCLES = 4,
   parameter int EXTRA_WAIT  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   output logic                bus_ready,
   input  logic [NUM_BUSY-1:0] adc_busy,
   input  logic [SAMPLE_W-1:0] adc1_data,
   input  logic [SAMPLE_W-1:0] adc2_data,
   output logic [1:0]          adc_cs_n,
   output logic                dac_cs_n,
   output logic                conv_rd_n,
   output logic                conv_wr_n,
   output logic                dac_chan_sel,
   output logic [SAMPLE_W-1:0] dac_data,
   output logic                dac_clr_n
);

   // elaboration-time parameter checks
   generate
      if (BASE_CYCLES < 2) begin : g_bad_base
         $error("BASE_CYCLES must be at least 2");
      end
      if (EXTRA_WAIT < 0) begin : g_bad_extra
         $error("EXTRA_WAIT must not be negative");
      end
      if (SAMPLE_W > BUS_W) begin : g_bad_width
         $error("SAMPLE_W must fit in BUS_W");
      end
      if (REGION_LSB < 3 || ADDR_W < REGION_LSB + 2) begin : g_bad_addr
         $error("address window too small for region decode");
      end
   endgenerate

   acc_kind_t          kind;
   logic [NUM_DEV-1:0] dev_sel;
   logic               dec_chan;
   logic               seq_done;
   logic               seq_active;
   logic [NUM_DEV-1:0] seq_dev_q;
   logic [NUM_DEV-1:0] seq_cs_n;
   logic               reg_ready;
   logic               conv_start;
   logic               clr_we;
   logic               clr_q;
   logic [BUS_W-1:0]   status_word;
   logic [BUS_W-1:0]   clr_word;
   logic [SAMPLE_W-1:0] adc_pick;
   logic [BUS_W-1:0]   adc_ext;

   adcdac_decode #(
      .ADDR_W     (ADDR_W),
      .REGION_LSB (REGION_LSB)
   ) u_decode (
      .addr     (bus_addr),
      .write    (bus_write),
      .kind     (kind),
      .dev_sel  (dev_sel),
      .dac_chan (dec_chan)
   );

   assign conv_start = bus_req && !seq_active && (kind == ACC_CONV);
   assign reg_ready  = bus_req && !seq_active && (kind != ACC_CONV);
   assign clr_we     = reg_ready && bus_write && (kind == ACC_CLEAR);

   adcdac_sequencer #(
      .BASE_CYCLES (BASE_CYCLES),
      .EXTRA_WAIT  (EXTRA_WAIT),
      .SAMPLE_W    (SAMPLE_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (conv_start),
      .dev_sel_in (dev_sel),
      .write_in   (bus_write),
      .chan_in    (dec_chan),
      .wdata_in   (bus_wdata[SAMPLE_W-1:0]),
      .done       (seq_done),
      .active     (seq_active),
      .dev_q      (seq_dev_q),
      .cs_n       (seq_cs_n),
      .rd_n       (conv_rd_n),
      .wr_n       (conv_wr_n),
      .dac_chan   (dac_chan_sel),
      .dac_data   (dac_data)
   );

   adcdac_ctrl_regs #(
      .BUS_W (BUS_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_we      (clr_we),
      .clr_wbit    (bus_wdata[0]),
      .busy_in     (adc_busy),
      .clr_q       (clr_q),
      .status_word (status_word),
      .clr_word    (clr_word)
   );

   assign adc_pick = seq_dev_q[DEV_ADC2] ? adc2_data : adc1_data;

   generate
      if (BUS_W > SAMPLE_W) begin : g_ext
         assign adc_ext = {{(BUS_W-SAMPLE_W){1'b0}}, adc_pick};
      end else begin : g_noext
         assign adc_ext = adc_pick;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (seq_done && !seq_dev_q[DEV_DAC]) begin
         bus_rdata = adc_ext;
      end else if (reg_ready && !bus_write) begin
         if (kind == ACC_STATUS)
            bus_rdata = status_word;
         else if (kind == ACC_CLEAR)
            bus_rdata = clr_word;
      end
   end

   assign bus_ready = seq_done | reg_ready;
   assign adc_cs_n  = seq_cs_n[DEV_ADC2:DEV_ADC1];
   assign dac_cs_n  = seq_cs_n[DEV_DAC];
   assign dac_clr_n = clr_q;

endmodule

// File: rtl/adcdac_bridge_chk.sv
module adcdac_bridge_chk #(
   parameter int ADDR_W      = 22,
   parameter int BUS_W       = 16,
   parameter int BASE_CYCLES = 4,
   parameter int EXTRA_WAIT  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              bus_ready,
   input logic [1:0]        adc_busy,
   input logic [1:0]        adc_cs_n,
   input logic              dac_cs_n,
   input logic              conv_rd_n,
   input logic              conv_wr_n,
   input logic              dac_clr_n
);

   localparam int CW = $clog2(BASE_CYCLES + EXTRA_WAIT + 2);
   localparam logic [CW-1:0] SHORT_LOW = CW'(BASE_CYCLES - 2);
   localparam logic [CW-1:0] LONG_LOW  = CW'(BASE_CYCLES + EXTRA_WAIT - 2);
   localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(4);

   logic [2:0]    all_cs;
   logic          any_cs;
   logic [CW-1:0] low_cnt;

   assign all_cs = {dac_cs_n, adc_cs_n};
   assign any_cs = (all_cs != 3'b111);

   // cycles with a select low before the current one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (any_cs)
         low_cnt <= low_cnt + CW'(1);
      else
         low_cnt <= '0;
   end

   // R11
   one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~all_cs) <= 1);

   // R11
   strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_rd_n || !conv_wr_n) |-> any_cs);

   // R11
   release_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && any_cs) |=> (all_cs == 3'b111));

   // R6
   access_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && any_cs) |-> (low_cnt == SHORT_LOW || low_cnt == LONG_LOW));

   // R7
   cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cs && !bus_ready) |=> $stable(all_cs));

   // R3
   clr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_write && bus_ready && bus_addr == CLR_ADDR) |=> $stable(dac_clr_n));

   // R2
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_write && bus_addr == '0 && !any_cs) |-> (bus_ready && bus_rdata == BUS_W'(adc_busy)));

endmodule

bind adcdac_bridge adcdac_bridge_chk #(
   .ADDR_W      (ADDR_W),
   .BUS_W       (BUS_W),
   .BASE_CYCLES (BASE_CYCLES),
   .EXTRA_WAIT  (EXTRA_WAIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .bus_ready (bus_ready),
   .adc_busy  (adc_busy),
   .adc_cs_n  (adc_cs_n),
   .dac_cs_n  (dac_cs_n),
   .conv_rd_n (conv_rd_n),
   .conv_wr_n (conv_wr_n),
   .dac_clr_n (dac_clr_n)
);

// File: tb/adcdac_bridge_test.sv
`timescale 1ns/1ps
module adcdac_bridge_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_write = 1'b0;
   logic [21:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_ready;
   logic [1:0]  adc_busy = 2'b00;
   logic [15:0] adc1_data = 16'h0000;
   logic [15:0] adc2_data = 16'h0000;
   logic [1:0]  adc_cs_n;
   logic        dac_cs_n;
   logic        conv_rd_n;
   logic        conv_wr_n;
   logic        dac_chan_sel;
   logic [15:0] dac_data;
   logic        dac_clr_n;

   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   logic [2:0] seen_cs;
   logic       seen_rd;
   logic       seen_wr;

   always #10 clk = ~clk;   // 50 MHz

   adcdac_bridge uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_req      (bus_req),
      .bus_write    (bus_write),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .bus_ready    (bus_ready),
      .adc_busy     (adc_busy),
      .adc1_data    (adc1_data),
      .adc2_data    (adc2_data),
      .adc_cs_n     (adc_cs_n),
      .dac_cs_n     (dac_cs_n),
      .conv_rd_n    (conv_rd_n),
      .conv_wr_n    (conv_wr_n),
      .dac_chan_sel (dac_chan_sel),
      .dac_data     (dac_data),
      .dac_clr_n    (dac_clr_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one bus access; ends right after the completing edge with req still high
   task automatic access(input bit w, input logic [21:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output int cyc);
      @(negedge clk);
      bus_req   = 1'b1;
      bus_write = w;
      bus_addr  = a;
      bus_wdata = d;
      seen_cs   = 3'b000;
      seen_rd   = 1'b0;
      seen_wr   = 1'b0;
      cyc       = 99;
      rd        = 16'hxxxx;
      for (int i = 1; i <= 20; i++) begin
         #1;
         seen_cs = seen_cs | ~{dac_cs_n, adc_cs_n};
         seen_rd = seen_rd | ~conv_rd_n;
         seen_wr = seen_wr | ~conv_wr_n;
         if (bus_ready) begin
            cyc = i;
            rd  = bus_rdata;
            break;
         end
         @(negedge clk);
      end
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      bus_req = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R10 reset selects", {29'd0, dac_cs_n, adc_cs_n}, 32'h7);
      chk("R10 reset strobes", {30'd0, conv_rd_n, conv_wr_n}, 32'h3);
      chk("R10 reset ready", {31'd0, bus_ready}, 32'h0);
      chk("R3 reset clear low", {31'd0, dac_clr_n}, 32'h0);
   endtask

   task automatic t_status();
      logic [15:0] rd;
      int c;
      for (int b = 0; b < 4; b++) begin
         adc_busy = b[1:0];
         access(1'b0, 22'h000000, 16'h0, rd, c);
         chk("R2 status bits", {16'd0, rd}, b);
         chk("R4 status one cycle", c, 1);
      end
      idle(1);
      access(1'b1, 22'h000000, 16'hFFFF, rd, c);
      #1;
      chk("R2 status write one cycle", c, 1);
      chk("R2 status write no select", {29'd0, seen_cs}, 0);
      chk("R2 status write clear untouched", {31'd0, dac_clr_n}, 0);
      idle(1);
   endtask

   task automatic t_clear();
      logic [15:0] rd;
      int c;
      access(1'b1, 22'h000004, 16'h0001, rd, c);
      #1;
      chk("R4 clear write one cycle", c, 1);
      chk("R3 clear set", {31'd0, dac_clr_n}, 1);
      access(1'b0, 22'h000004, 16'h0, rd, c);
      chk("R3 clear readback 1", {16'd0, rd}, 1);
      access(1'b1, 22'h000004, 16'hFFFE, rd, c);
      #1;
      chk("R3 clear low from bit0", {31'd0, dac_clr_n}, 0);
      access(1'b0, 22'h000004, 16'h0, rd, c);
      chk("R3 clear readback 0", {16'd0, rd}, 0);
      access(1'b1, 22'h000004, 16'h0001, rd, c);
      idle(1);
   endtask

   task automatic t_adc();
      logic [15:0] rd;
      int c;
      adc1_data = 16'h1234;
      adc2_data = 16'hBEEF;
      access(1'b0, 22'h100000, 16'h0, rd, c);
      chk("R5 ADC1 length", c, 4);
      chk("R7 R1 ADC1 data", {16'd0, rd}, 32'h1234);
      chk("R7 ADC1 select only", {29'd0, seen_cs}, 32'h1);
      chk("R7 ADC1 strobes", {30'd0, seen_rd, seen_wr}, 32'h2);
      idle(2);
      access(1'b0, 22'h200000, 16'h0, rd, c);
      chk("R5 ADC2 length", c, 4);
      chk("R7 R1 ADC2 data", {16'd0, rd}, 32'hBEEF);
      chk("R7 ADC2 select only", {29'd0, seen_cs}, 32'h2);
      idle(1);
      #1;
      chk("R11 selects released", {29'd0, dac_cs_n, adc_cs_n}, 32'h7);
   endtask

   task automatic t_dac();
      logic [15:0] rd;
      int c;
      access(1'b1, 22'h300000, 16'h0ABC, rd, c);
      #1;
      chk("R5 DAC A length", c, 4);
      chk("R8 DAC select only", {29'd0, seen_cs}, 32'h4);
      chk("R8 DAC strobes", {30'd0, seen_rd, seen_wr}, 32'h1);
      chk("R8 DAC A data", {16'd0, dac_data}, 32'h0ABC);
      chk("R8 R1 DAC A channel", {31'd0, dac_chan_sel}, 0);
      idle(2);
      access(1'b1, 22'h300004, 16'h5555, rd, c);
      #1;
      chk("R8 DAC B data", {16'd0, dac_data}, 32'h5555);
      chk("R8 R1 DAC B channel", {31'd0, dac_chan_sel}, 1);
      idle(1);
   endtask

   task automatic t_chain();
      logic [15:0] rd;
      int c;
      adc1_data = 16'h0F0F;
      adc2_data = 16'hA5A5;
      access(1'b0, 22'h100000, 16'h0, rd, c);
      chk("R6 chain first", c, 4);
      access(1'b1, 22'h300004, 16'h3C3C, rd, c);
      chk("R6 chain second", c, 7);
      chk("R8 chained DAC data", {16'd0, dac_data}, 32'h3C3C);
      access(1'b0, 22'h200000, 16'h0, rd, c);
      chk("R6 chain third", c, 7);
      chk("R7 chained ADC2 data", {16'd0, rd}, 32'hA5A5);
      idle(1);
      access(1'b0, 22'h100000, 16'h0, rd, c);
      chk("R6 idle gap resets", c, 4);
      access(1'b0, 22'h000000, 16'h0, rd, c);
      chk("R4 status after converter", c, 1);
      access(1'b0, 22'h200000, 16'h0, rd, c);
      chk("R6 register access resets", c, 4);
      idle(1);
   endtask

   task automatic t_unmapped();
      logic [15:0] rd;
      int c;
      access(1'b0, 22'h000008, 16'h0, rd, c);
      chk("R9 unmapped read data", {16'd0, rd}, 0);
      chk("R9 unmapped read one cycle", c, 1);
      access(1'b1, 22'h000008, 16'h0000, rd, c);
      #1;
      chk("R9 unmapped write ignored", {31'd0, dac_clr_n}, 1);
      access(1'b1, 22'h100000, 16'h7777, rd, c);
      chk("R9 ADC write one cycle", c, 1);
      chk("R9 ADC write no select", {29'd0, seen_cs}, 0);
      access(1'b0, 22'h300000, 16'h0, rd, c);
      chk("R9 DAC read data", {16'd0, rd}, 0);
      chk("R9 DAC read no strobe", {29'd0, seen_cs | {seen_rd, seen_rd, seen_wr}}, 0);
      access(1'b0, 22'h100004, 16'h0, rd, c);
      chk("R1 ADC offset 4 unmapped", c, 1);
      access(1'b1, 22'h000006, 16'h0000, rd, c);
      #1;
      chk("R1 misaligned clear ignored", {31'd0, dac_clr_n}, 1);
      chk("R9 DAC data untouched", {16'd0, dac_data}, 32'h3C3C);
      idle(1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      t_reset();
      t_status();
      t_clear();
      t_adc();
      t_dac();
      t_chain();
      t_unmapped();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule